// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 64-word by 16-bit serial memory that a host reaches over four wires: a chip select, a shift clock, a data input and a data output. The block runs on a fast system clock. It passes the three incoming lines through synchronizers and finds rising shift-clock edges inside the block. Once chip select is high, the first 1 shifted in starts an instruction. A two-bit opcode and a six-bit address follow. Some instructions also carry a 16-bit data word. The block then reads, writes or erases words in an internal register array, or it sets or clears a write-enable latch.

A programmable count of system-clock cycles stands in for the self-timed programming delay. After any programming command has been launched, the host drops chip select and raises it again. The data output then shows whether the block is still busy or ready. The output is modelled as a data bit plus a separate output-enable, so the released (high-impedance) state can be seen directly.

The frame state machine has five states:
- `ST_IDLE`: waiting for a start bit, and showing status when status is armed.
- `ST_CMD`: shifting in the opcode and address.
- `ST_DATA`: shifting in a data word.
- `ST_RDOUT`: shifting a word out.
- `ST_WAITCS`: the frame is finished and the block waits for chip select to fall.

Its transitions are:
- start accepted: `ST_IDLE` to `ST_CMD`.
- read decoded: `ST_CMD` to `ST_RDOUT`.
- write or fill decoded: `ST_CMD` to `ST_DATA`.
- other command decoded: `ST_CMD` to `ST_WAITCS`.
- last data bit: `ST_DATA` to `ST_WAITCS`.
- last bit shifted out: `ST_RDOUT` to `ST_WAITCS`.
- deselect: any state to `ST_IDLE`.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the write-enable latch is clear, every word of the array reads 16'hFFFF, and the data output is not enabled.
- R2: While chip select is high, 0 bits before the first 1 are ignored. That 1 is the start bit. It is followed by two opcode bits and then six address bits, all sampled on rising shift-clock edges with the most significant bit first.
- R3: Opcode 10 (read) makes the output enable assert and data out go to 0 (a dummy bit) on the edge that takes the last address bit. Each later rising edge then presents the next bit of the stored word, starting with bit 15. Reads work whether the latch is set or clear.
- R4: Opcode 01 (write) takes 16 data bits, MSB first, after the address. When the latch is set, the word is stored at the address.
- R5: Opcode 11 (erase) sets the addressed word to 16'hFFFF. Opcode 00 with address bits [5:4]=10 (erase-all) sets every word to 16'hFFFF. Both act when the latch is set.
- R6: Opcode 00 with address bits [5:4]=01 (fill) takes 16 data bits. When the latch is set, it writes that word to every location.
- R7: Opcode 00 with address bits [5:4]=11 sets the latch, and with 00 clears it. Bits [3:0] are don't-care. A write, erase, erase-all or fill received while the latch is clear changes no word and starts no busy period.
- R8: A launched programming command keeps the block busy for PROG_CYCLES system clocks. While status is armed and chip select is high in idle, data out is enabled and reads 0 while busy and 1 when ready.
- R9: While busy, start bits are not accepted, so a frame sent during that time has no effect.
- R10: Lowering chip select before a frame completes cancels it and leaves the array unchanged.
- R11: The data output enable is low whenever the synchronized chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, asynchronous to clk |
| sk | input | 1 | Serial shift clock, asynchronous to clk |
| di | input | 1 | Serial data in |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Enable for do_data; low means released |

## Verification
The hardest case to reach from the ports is a complete frame that arrives while a programming delay is still running. That frame must be ignored, and the rest of its bit stream must not be mistaken for a new start bit. To reach it, the bench launches a write with a programming delay much longer than one frame. It re-raises chip select and shifts a second full write frame into the busy window. After waiting for ready, it reads the second address back. Random addresses and data from a fixed seed drive the ordinary write and read-back traffic. Directed frames cover the other cases: leading zeros, a mid-frame abort, the fill and erase-all commands, and commands sent with the latch clear.

// File: rtl/see_pkg.sv
package see_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_RDOUT,
        ST_WAITCS
    } state_t;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opcode_t;

    typedef enum logic [1:0] {
        EX_LOCK   = 2'b00,
        EX_FILL   = 2'b01,
        EX_CLRALL = 2'b10,
        EX_UNLOCK = 2'b11
    } ext_t;
endpackage

// File: rtl/see_sync.sv
module see_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/see_array.sv
module see_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[w] <= '1;
                else if (we_all || (we_one && waddr == ADDR_W'(w)))
                    mem[w] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[raddr];
endmodule

// File: rtl/see_timer.sv
module see_timer #(
    parameter int PROG_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= CW'(PROG_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_data,
    output logic do_oe
);
    import see_pkg::*;

    localparam int OPC_W = 2;
    localparam int CMD_W = OPC_W + ADDR_W;
    localparam int MAXB  = (DATA_W > CMD_W) ? DATA_W : CMD_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    // input synchronizers and edge detect
    logic [2:0] pins_s;
    logic       cs_s, sk_s, di_s, sk_q, sk_rise;

    see_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs, sk, di}), .q(pins_s)
    );
    assign {cs_s, sk_s, di_s} = pins_s;
    assign sk_rise = sk_s & ~sk_q;

    // state and datapath registers
    state_t             state, state_nx;
    logic [CNT_W-1:0]   bitcnt;
    logic [CMD_W-1:0]   cmd_sh;
    logic [DATA_W-1:0]  data_sh;
    logic [DATA_W:0]    out_sh;
    logic [ADDR_W-1:0]  addr_q;
    logic               fill_q;
    logic               wen_q;
    logic               stat_q;
    logic               busy;

    // decode of the frame as it completes
    logic [CMD_W-1:0]   cmd_full;
    opcode_t            opcode;
    logic [ADDR_W-1:0]  addr_in;
    ext_t               ext;
    logic [DATA_W-1:0]  data_full;
    logic               start_ok, last_cmd, last_data, last_out;

    assign cmd_full  = {cmd_sh[CMD_W-2:0], di_s};
    assign opcode    = opcode_t'(cmd_full[CMD_W-1 -: OPC_W]);
    assign addr_in   = cmd_full[ADDR_W-1:0];
    assign ext       = ext_t'(addr_in[ADDR_W-1 -: 2]);
    assign data_full = {data_sh[DATA_W-2:0], di_s};

    assign start_ok  = (state == ST_IDLE) && cs_s && sk_rise && di_s && !busy;
    assign last_cmd  = (state == ST_CMD) && sk_rise && (bitcnt == CNT_W'(CMD_W - 1));
    assign last_data = (state == ST_DATA) && sk_rise && (bitcnt == CNT_W'(DATA_W - 1));
    assign last_out  = (state == ST_RDOUT) && sk_rise && (bitcnt == CNT_W'(DATA_W));

    // array and programming timer
    logic              arr_we_one, arr_we_all, prog_start;
    logic [ADDR_W-1:0] arr_waddr;
    logic [DATA_W-1:0] arr_wdata, arr_rdata;

    see_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .we_one(arr_we_one), .we_all(arr_we_all),
        .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(addr_in), .rdata(arr_rdata)
    );

    see_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) state_nx = ST_CMD;
            end
            ST_CMD: begin
                if (!cs_s)
                    state_nx = ST_IDLE;
                else if (last_cmd) begin
                    unique case (opcode)
                        OP_READ:  state_nx = ST_RDOUT;
                        OP_WRITE: state_nx = ST_DATA;
                        OP_ERASE: state_nx = ST_WAITCS;
                        OP_EXT:   state_nx = (ext == EX_FILL) ? ST_DATA : ST_WAITCS;
                        default:  state_nx = ST_WAITCS;
                    endcase
                end
            end
            ST_DATA: begin
                if (!cs_s)          state_nx = ST_IDLE;
                else if (last_data) state_nx = ST_WAITCS;
            end
            ST_RDOUT: begin
                if (!cs_s)         state_nx = ST_IDLE;
                else if (last_out) state_nx = ST_WAITCS;
            end
            ST_WAITCS: begin
                if (!cs_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // programming launch
    always_comb begin
        arr_we_one = 1'b0;
        arr_we_all = 1'b0;
        prog_start = 1'b0;
        arr_waddr  = last_cmd ? addr_in : addr_q;
        arr_wdata  = '1;
        if (last_cmd && cs_s && wen_q) begin
            if (opcode == OP_ERASE) begin
                arr_we_one = 1'b1;
                prog_start = 1'b1;
            end else if (opcode == OP_EXT && ext == EX_CLRALL) begin
                arr_we_all = 1'b1;
                prog_start = 1'b1;
            end
        end
        if (last_data && cs_s && wen_q) begin
            arr_wdata  = data_full;
            arr_we_all = fill_q;
            arr_we_one = ~fill_q;
            prog_start = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q    <= 1'b0;
            bitcnt  <= '0;
            cmd_sh  <= '0;
            data_sh <= '0;
            out_sh  <= '0;
            addr_q  <= '0;
            fill_q  <= 1'b0;
            wen_q   <= 1'b0;
            stat_q  <= 1'b0;
        end else begin
            sk_q <= sk_s;
            if (state_nx != state)
                bitcnt <= '0;
            else if (sk_rise)
                bitcnt <= bitcnt + 1'b1;
            if (state == ST_CMD && sk_rise)
                cmd_sh <= cmd_full;
            if (state == ST_DATA && sk_rise)
                data_sh <= data_full;
            if (last_cmd)
                out_sh <= {1'b0, arr_rdata};
            else if (state == ST_RDOUT && sk_rise)
                out_sh <= {out_sh[DATA_W-1:0], 1'b0};
            if (last_cmd) begin
                addr_q <= addr_in;
                fill_q <= (opcode == OP_EXT);
                if (cs_s && opcode == OP_EXT && ext == EX_UNLOCK) wen_q <= 1'b1;
                if (cs_s && opcode == OP_EXT && ext == EX_LOCK)   wen_q <= 1'b0;
            end
            if (prog_start)
                stat_q <= 1'b1;
            else if (start_ok)
                stat_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        do_oe   = 1'b0;
        do_data = 1'b0;
        unique case (state)
            ST_RDOUT: begin
                do_oe   = cs_s;
                do_data = out_sh[DATA_W];
            end
            ST_IDLE: begin
                do_oe   = cs_s & stat_q;
                do_data = ~busy;
            end
            default: begin
                do_oe   = 1'b0;
                do_data = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/see_checker.sv
module see_checker (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input see_pkg::state_t  state,
    input logic             busy,
    input logic             prog_start,
    input logic             mem_we,
    input logic             wen,
    input logic             do_oe,
    input logic             do_data
);
    import see_pkg::*;

    assert_hiz_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !do_oe);

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && busy) |=> state == ST_IDLE);

    assert_launch_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    assert_locked_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen);

    assert_read_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDOUT && $past(state) == ST_CMD) |-> (do_oe && !do_data));

    assert_abort_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !cs_s) |=> state == ST_IDLE);
endmodule

bind serial_eeprom_slave see_checker u_see_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .state(state), .busy(busy),
    .prog_start(prog_start), .mem_we(arr_we_one | arr_we_all), .wen(wen_q),
    .do_oe(do_oe), .do_data(do_data)
);

// File: tb/serial_eeprom_slave_bench.sv
`timescale 1ns/1ps
module serial_eeprom_slave_bench;
    localparam int PROG = 1500;
    localparam int H    = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_data, do_oe;
    int   total = 0, bad = 0, cyc = 0;
    logic [15:0] model [64];

    serial_eeprom_slave #(.PROG_CYCLES(PROG)) u_serial_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_data(do_data), .do_oe(do_oe)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic sk_cycle(input logic b);
        di = b;
        repeat (H) @(negedge clk);
        sk = 1'b1;
        repeat (H) @(negedge clk);
        sk = 1'b0;
    endtask

    task automatic cs_on();
        @(negedge clk) cs = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_off();
        cs = 1'b0; di = 1'b0;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic head(input logic [1:0] op, input logic [5:0] a, input int lead);
        for (int i = 0; i < lead; i++) sk_cycle(1'b0);
        sk_cycle(1'b1);
        for (int i = 1; i >= 0; i--) sk_cycle(op[i]);
        for (int i = 5; i >= 0; i--) sk_cycle(a[i]);
    endtask

    task automatic word_out(input logic [15:0] d, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) sk_cycle(d[i]);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v, output logic dummy);
        cs_on();
        head(2'b10, a, 0);
        dummy = do_oe ? do_data : 1'bx;
        v = '0;
        for (int i = 0; i < 16; i++) begin
            sk_cycle(1'b0);
            v = {v[14:0], do_data};
        end
        cs_off();
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input int lead);
        cs_on(); head(2'b01, a, lead); word_out(d, 16); cs_off();
    endtask

    task automatic ext(input logic [1:0] code, input logic [15:0] d);
        cs_on(); head(2'b00, {code, 4'b1010}, 0);
        if (code == 2'b01) word_out(d, 16);
        cs_off();
    endtask

    task automatic erase(input logic [5:0] a);
        cs_on(); head(2'b11, a, 0); cs_off();
    endtask

    task automatic wait_ready(output int n);
        cs_on();
        n = 0;
        while (do_data !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        cs_off();
    endtask

    function automatic logic [15:0] expect_word(input logic [5:0] a);
        return model[a];
    endfunction

    initial begin
        logic [15:0] v;
        logic        dm;
        int          n;
        logic [5:0]  a, b;
        logic [15:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 oe after reset", {31'b0, do_oe}, 32'h0);

        rd(6'd5, v, dm);
        chk("R1 erased after reset", {16'b0, v}, 32'hFFFF);
        chk("R3 dummy bit", {31'b0, dm}, 32'h0);

        // locked write: no change, no busy
        wr(6'd5, 16'h1234, 0);
        cs_on();
        chk("R7 no busy when locked", {31'b0, do_oe}, 32'h0);
        cs_off();
        rd(6'd5, v, dm);
        chk("R7 locked write discarded", {16'b0, v}, 32'hFFFF);

        ext(2'b11, 16'h0);  // unlock
        for (int k = 0; k < 8; k++) begin
            a = 6'($urandom % 64);
            d = 16'($urandom);
            wr(a, d, (k == 0) ? 3 : 0);
            model[a] = d;
            cs_on();
            chk("R8 busy status", {30'b0, do_oe, do_data}, 32'h2);
            cs_off();
            wait_ready(n);
            if (k == 0) begin
                chk("R8 busy duration", {31'b0, (n > PROG - 100 && n < PROG)}, 32'h1);
                rd(a, v, dm);
                chk("R2 leading zeros ignored", {16'b0, v}, {16'b0, expect_word(a)});
            end else begin
                rd(a, v, dm);
                chk("R4 write readback", {16'b0, v}, {16'b0, expect_word(a)});
            end
            chk("R3 dummy", {31'b0, dm}, 32'h0);
        end

        // frame during busy is ignored
        a = 6'd10; b = 6'd11;
        wr(a, 16'hA5A5, 0); model[a] = 16'hA5A5;
        wr(b, 16'h0F0F, 0);
        wait_ready(n);
        rd(b, v, dm);
        chk("R9 busy frame ignored", {16'b0, v}, {16'b0, expect_word(b)});
        rd(a, v, dm);
        chk("R4 write before busy", {16'b0, v}, 32'hA5A5);

        // abort mid-frame
        cs_on(); head(2'b01, a, 0); word_out(16'h0000, 8); cs_off();
        cs_on();
        chk("R10 abort no busy", {31'b0, do_oe}, 32'h0);
        cs_off();
        rd(a, v, dm);
        chk("R10 abort unchanged", {16'b0, v}, 32'hA5A5);

        // deselect during read releases DO
        cs_on(); head(2'b10, a, 0); sk_cycle(1'b0);
        cs = 1'b0;
        repeat (H) @(negedge clk);
        chk("R11 released on deselect", {31'b0, do_oe}, 32'h0);
        cs_off();

        erase(a); model[a] = 16'hFFFF;
        wait_ready(n);
        rd(a, v, dm);
        chk("R5 erase word", {16'b0, v}, 32'hFFFF);

        ext(2'b01, 16'h3C96);
        for (int i = 0; i < 64; i++) model[i] = 16'h3C96;
        wait_ready(n);
        for (int k = 0; k < 3; k++) begin
            a = 6'($urandom % 64);
            rd(a, v, dm);
            chk("R6 fill", {16'b0, v}, {16'b0, expect_word(a)});
        end

        ext(2'b10, 16'h0);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        wait_ready(n);
        rd(6'd63, v, dm);
        chk("R5 erase all", {16'b0, v}, 32'hFFFF);

        wr(6'd1, 16'h5555, 0); model[1] = 16'h5555;
        wait_ready(n);
        ext(2'b00, 16'h0);  // lock
        wr(6'd1, 16'h1111, 0);
        erase(6'd1);
        cs_on();
        chk("R7 locked no status", {31'b0, do_oe}, 32'h0);
        cs_off();
        rd(6'd1, v, dm);
        chk("R7 lock keeps word", {16'b0, v}, {16'b0, expect_word(6'd1)});
        chk("R3 read while locked", {31'b0, dm}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule